// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block sequences successive-approximation conversions for a model converter. Software programs two control registers over a small write-only bus. One register holds the debug-freeze policy. The other holds the resolution, the sample length and the clock prescaler. Writing the start register launches a sequence of `SEQ_LEN` conversions.

Each conversion has three phases:
- a fixed buffered-sample-and-transfer phase of `BUF_TICKS` conversion-clock ticks;
- a programmable sample phase;
- one successive-approximation step per result bit.

During the steps the block presents a trial code to the converter and reads back a one-bit comparator answer. Every finished conversion updates a right-justified 10-bit result and gives a one-cycle pulse. After the last conversion of the sequence a sticky done flag rises.

Any control-register write abandons the running sequence. The block then stays idle until the start register is written again. A debug-halt input is honoured according to the freeze policy. The block can ignore the halt, let the current conversion finish and then wait, or stall at once and resume exactly where it stopped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `done_o`, `samp_o` and `conv_done_o` are 0, and `trial_o` and `result_o` are 0. The clock register resets to 0x01: prescaler 1, sample code 00, 8-bit mode. With these defaults a start write at edge E0 makes `done_o` rise at edge E0 + SEQ_LEN·48.
- R2: The register map is decoded from `wr_addr`.
  - Address 0: bits [1:0] hold the freeze field.
  - Address 1: bit 7 selects resolution (0 = 8-bit, 1 = 10-bit), bits [6:5] hold the sample code and bits [4:0] hold the prescaler value P.
  - Address 2: a write with any data starts a sequence.
- R3: One conversion-clock tick lasts 2·(P+1) system clocks.
  - A conversion lasts (BUF_TICKS + S + N) ticks. S is 2, 4, 8 or 16 for sample codes 0 to 3. N is 8 or 10 steps.
  - A sequence is SEQ_LEN back-to-back conversions, counted from the start-write edge E0. `done_o` rises exactly at edge E0 + SEQ_LEN·T, where T is the conversion length in system clocks.
  - `conv_done_o` pulses once per finished conversion.
- R4: `cmp_i` is 1 when the analog input is at or above `trial_o`. Given that, the result is the input code. In 8-bit mode the result occupies bits [7:0] and bits [9:8] read 0.
- R5: `samp_o` is 1 during the buffer and sample phases, and `trial_o` is then 0. During the steps `samp_o` is 0 and `trial_o` holds the bits decided so far plus the bit under test, starting at 0x80 in 8-bit mode.
- R6: A write to address 0 or 1 returns the block to idle in the same edge. `samp_o` and `trial_o` go to 0 and `done_o` clears. No done or conversion pulse follows until the next start write.
- R7: A start write during a sequence restarts it from its first phase, with timing counted from the new write. A start write clears `done_o`.
- R8: With freeze field 00 or 01, `dbg_halt` has no effect on timing or results.
- R9: With freeze field 10, a halt seen when a conversion ends lets that conversion finish and then holds before the next one. While holding, `samp_o` = 0, `trial_o` = 0 and `result_o` shows the finished conversion. At the first edge Er that samples the halt low, a fresh conversion starts, and `done_o` rises at Er + (SEQ_LEN−1)·T.
- R10: With freeze field 11, each edge at which `dbg_halt` is 1 leaves the whole sequence frozen. `trial_o` and `samp_o` stay unchanged, and completion is delayed by exactly the number of halted edges.
- R11: If a control write lands on the same edge as the final conversion's completion, the abort wins. Neither `done_o` nor that conversion's pulse appears.
- R12: A write to address 3 is ignored: a running sequence keeps its timing and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Register write data |
| dbg_halt | input | 1 | Debug halt request |
| cmp_i | input | 1 | Comparator answer from the converter: 1 if input is at or above trial code |
| samp_o | output | 1 | Converter should track the input (buffer and sample phases) |
| trial_o | output | 10 | Trial code under test; 0 outside the step phase |
| conv_done_o | output | 1 | One-cycle pulse after each finished conversion |
| result_o | output | 10 | Right-justified result of the latest finished conversion |
| done_o | output | 1 | Sticky sequence-complete flag |

## Verification
The colliding pair is a control-register write and the completion of the final conversion of a sequence. Both act on the same clock edge: one would set the done flag, the other must clear it.

The bench computes the exact completion edge from the programmed prescaler, sample code and resolution. It then issues an abort write on precisely that edge. It judges the outcome at the ports: `done_o` must stay low afterwards, and exactly one conversion pulse fewer than a full sequence must have appeared. The freeze-stop test gives a second timing judgement, where completion must move by exactly the count of halted edges.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int FRZ_W  = 2;
    localparam int SMP_W  = 2;
    localparam int PRS_W  = 5;
    localparam int RES_HI = 10;
    localparam int RES_LO = 8;
    localparam int PH_W   = (1 << SMP_W) + 1;

    localparam logic [ADDR_W-1:0] ADDR_FRZ = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CLK = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_GO  = 2'd2;

    localparam int CLK_RES_BIT = 7;
    localparam int CLK_SMP_LSB = 5;

    typedef enum logic [FRZ_W-1:0] {
        FRZ_RUN    = 2'b00,
        FRZ_RSVD   = 2'b01,
        FRZ_FINISH = 2'b10,
        FRZ_STOP   = 2'b11
    } frz_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BUF,
        PH_SAMP,
        PH_CONV,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        frz_t             frz;
        logic             res10;
        logic [SMP_W-1:0] smp;
        logic [PRS_W-1:0] prs;
    } cfg_t;

    function automatic logic [PH_W-1:0] smp_ticks(input logic [SMP_W-1:0] code);
        return PH_W'(2) << code;
    endfunction

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic              ctl_wr,
    output logic              start_wr
);

    assign ctl_wr   = wr_en && (wr_addr == ADDR_FRZ || wr_addr == ADDR_CLK);
    assign start_wr = wr_en && (wr_addr == ADDR_GO);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.frz   <= FRZ_RUN;
            cfg.res10 <= 1'b0;
            cfg.smp   <= '0;
            cfg.prs   <= PRS_W'(1);
        end else if (wr_en) begin
            if (wr_addr == ADDR_FRZ) begin
                cfg.frz <= frz_t'(wr_data[FRZ_W-1:0]);
            end else if (wr_addr == ADDR_CLK) begin
                cfg.res10 <= wr_data[CLK_RES_BIT];
                cfg.smp   <= wr_data[CLK_SMP_LSB +: SMP_W];
                cfg.prs   <= wr_data[PRS_W-1:0];
            end
        end
    end

endmodule

// File: rtl/adc_seq_presc.sv
module adc_seq_presc #(
    parameter int PRS_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [PRS_W-1:0] prs,
    output logic             tick
);

    localparam int CNT_W = PRS_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // period 2*(prs+1) means terminal count 2*prs+1
    assign lim  = {prs, 1'b1};
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R3: a tick is never followed directly by another tick
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int RES_HI = 10,
    parameter int RES_LO = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic              active,
    input  logic              res10,
    input  logic              cmp_i,
    output logic [RES_HI-1:0] trial,
    output logic              last,
    output logic [RES_HI-1:0] result
);

    localparam int IDX_W = $clog2(RES_HI);

    logic [RES_HI-1:0] acc;
    logic [IDX_W-1:0]  idx;
    logic [RES_HI-1:0] probe;

    assign probe = acc | ({{(RES_HI-1){1'b0}}, 1'b1} << idx);
    assign trial = active ? probe : '0;
    assign last  = (idx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            idx    <= '0;
            result <= '0;
        end else if (load) begin
            acc <= '0;
            idx <= res10 ? IDX_W'(RES_HI - 1) : IDX_W'(RES_LO - 1);
        end else if (step) begin
            acc <= cmp_i ? probe : acc;
            if (last) begin
                result <= cmp_i ? probe : acc;
            end else begin
                idx <= idx - 1'b1;
            end
        end
    end

    // R4: a narrow conversion leaves the upper result bits clear
    a_r4_narrow_result: assert property (@(posedge clk) disable iff (rst)
        (step && last && !res10) |=> (result[RES_HI-1:RES_LO] == '0));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SEQ_LEN   = 4,
    parameter int BUF_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              dbg_halt,
    input  logic              cmp_i,
    output logic              samp_o,
    output logic [RES_HI-1:0] trial_o,
    output logic              conv_done_o,
    output logic [RES_HI-1:0] result_o,
    output logic              done_o
);

    localparam int SEQ_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(SEQ_LEN - 1);
    localparam logic [PH_W-1:0]  BUF_LAST = PH_W'(BUF_TICKS - 1);

    cfg_t             cfg;
    logic             ctl_wr;
    logic             start_wr;
    logic             any_wr;
    phase_t           state;
    logic [PH_W-1:0]  ph_cnt;
    logic [SEQ_W-1:0] seq_idx;
    logic             running;
    logic             stall;
    logic             tick;
    logic             presc_clr;
    logic             sar_load;
    logic             sar_step;
    logic             sar_last;
    logic             conv_end;
    logic [PH_W-1:0]  smp_last;

    adc_seq_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .ctl_wr   (ctl_wr),
        .start_wr (start_wr)
    );

    assign any_wr    = ctl_wr || start_wr;
    assign running   = (state == PH_BUF) || (state == PH_SAMP) || (state == PH_CONV);
    assign stall     = (cfg.frz == FRZ_STOP) && dbg_halt;
    assign presc_clr = any_wr || !running;
    assign smp_last  = smp_ticks(cfg.smp) - 1'b1;

    adc_seq_presc #(.PRS_W(PRS_W)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (presc_clr),
        .run  (running && !stall),
        .prs  (cfg.prs),
        .tick (tick)
    );

    assign sar_load = !any_wr && tick && (state == PH_SAMP) && (ph_cnt == smp_last);
    assign sar_step = !any_wr && tick && (state == PH_CONV);
    assign conv_end = sar_step && sar_last;

    adc_seq_sar #(.RES_HI(RES_HI), .RES_LO(RES_LO)) u_sar (
        .clk    (clk),
        .rst    (rst),
        .load   (sar_load),
        .step   (sar_step),
        .active (state == PH_CONV),
        .res10  (cfg.res10),
        .cmp_i  (cmp_i),
        .trial  (trial_o),
        .last   (sar_last),
        .result (result_o)
    );

    assign samp_o = (state == PH_BUF) || (state == PH_SAMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PH_IDLE;
            ph_cnt      <= '0;
            seq_idx     <= '0;
            done_o      <= 1'b0;
            conv_done_o <= 1'b0;
        end else begin
            conv_done_o <= 1'b0;
            if (ctl_wr) begin
                state   <= PH_IDLE;
                ph_cnt  <= '0;
                seq_idx <= '0;
                done_o  <= 1'b0;
            end else if (start_wr) begin
                state   <= PH_BUF;
                ph_cnt  <= '0;
                seq_idx <= '0;
                done_o  <= 1'b0;
            end else begin
                case (state)
                    PH_BUF: if (tick) begin
                        if (ph_cnt == BUF_LAST) begin
                            state  <= PH_SAMP;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                    PH_SAMP: if (tick) begin
                        if (ph_cnt == smp_last) begin
                            state  <= PH_CONV;
                            ph_cnt <= '0;
                        end else begin
                            ph_cnt <= ph_cnt + 1'b1;
                        end
                    end
                    PH_CONV: if (conv_end) begin
                        conv_done_o <= 1'b1;
                        if (seq_idx == SEQ_LAST) begin
                            state  <= PH_IDLE;
                            done_o <= 1'b1;
                        end else begin
                            seq_idx <= seq_idx + 1'b1;
                            state   <= ((cfg.frz == FRZ_FINISH) && dbg_halt) ? PH_HOLD : PH_BUF;
                        end
                    end
                    PH_HOLD: if (!dbg_halt) begin
                        state  <= PH_BUF;
                        ph_cnt <= '0;
                    end
                    default: state <= PH_IDLE;
                endcase
            end
        end
    end

    // R6: an abort write leaves the converter idle with done cleared
    a_r6_abort_idle: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (!done_o && !samp_o && trial_o == '0));

    // R5: no trial code is presented while the converter tracks
    a_r5_no_trial_in_sample: assert property (@(posedge clk) disable iff (rst)
        samp_o |-> (trial_o == '0));

    // R10: a stop-freeze halt holds the converter handshake still
    a_r10_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (stall && running && !wr_en) |=> ($stable(trial_o) && $stable(samp_o) && $stable(done_o)));

    // R3: completion comes together with the final conversion pulse
    a_r3_done_with_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> conv_done_o);

    // R7: done stays set until some register write
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_o && !wr_en) |=> done_o);

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int L = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       dbg_halt = 1'b0;
    logic       cmp_i;
    logic       samp_o;
    logic [9:0] trial_o;
    logic       conv_done_o;
    logic [9:0] result_o;
    logic       done_o;

    logic [9:0] vin = 10'd0;
    logic       b_res10 = 1'b0;
    int         pulses = 0;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.SEQ_LEN(L), .BUF_TICKS(2)) dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .dbg_halt    (dbg_halt),
        .cmp_i       (cmp_i),
        .samp_o      (samp_o),
        .trial_o     (trial_o),
        .conv_done_o (conv_done_o),
        .result_o    (result_o),
        .done_o      (done_o)
    );

    // comparator model: input at or above the trial code
    assign cmp_i = b_res10 ? (trial_o <= vin) : (trial_o <= {2'b00, vin[9:2]});

    always @(posedge clk) if (conv_done_o) pulses <= pulses + 1;

    function automatic int conv_len(input bit r10, input int smp, input int prs);
        return (2 + (2 << smp) + (r10 ? 10 : 8)) * 2 * (prs + 1);
    endfunction

    function automatic logic [9:0] exp_res();
        return b_res10 ? vin : {2'b00, vin[9:2]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cfg_clk(input bit r10, input int smp, input int prs);
        b_res10 = r10;
        wr(2'd1, {r10, smp[1:0], prs[4:0]});
    endtask

    // done must rise exactly k edges after the edge just passed
    task automatic expect_done(input int k, input string req);
        repeat (k - 1) @(negedge clk);
        chk(done_o == 1'b0, req, done_o, 0);
        @(negedge clk);
        chk(done_o == 1'b1, req, done_o, 1);
    endtask

    task automatic t_reset();
        chk(done_o == 0 && samp_o == 0 && conv_done_o == 0, "R1 reset flags",
            {done_o, samp_o, conv_done_o}, 0);
        chk(trial_o == 0 && result_o == 0, "R1 reset data", {trial_o, result_o}, 0);
    endtask

    task automatic t_default_seq();
        int p0;
        vin = 10'h2A5; b_res10 = 1'b0;
        p0 = pulses;
        wr(2'd2, 8'h00);
        chk(samp_o == 1 && trial_o == 0, "R5 buffer phase", {samp_o, trial_o}, 11'h400);
        repeat (16) @(negedge clk);
        chk(samp_o == 0 && trial_o == 10'h080, "R5 first step trial", {samp_o, trial_o}, 10'h080);
        expect_done(L * 48 - 16, "R1 default timing");
        chk(result_o == 10'h0A9, "R4 8-bit result", result_o, 10'h0A9);
        @(negedge clk);
        chk(pulses - p0 == L, "R3 pulse count", pulses - p0, L);
    endtask

    task automatic t_modes();
        vin = 10'h2A5;
        cfg_clk(1'b1, 3, 2);
        wr(2'd2, 8'h5A);
        expect_done(L * conv_len(1'b1, 3, 2), "R3 10-bit smp3 prs2 timing");
        chk(result_o == 10'h2A5, "R4 10-bit result", result_o, 10'h2A5);
        vin = 10'h3FF;
        cfg_clk(1'b1, 1, 0);
        wr(2'd2, 8'h00);
        expect_done(L * conv_len(1'b1, 1, 0), "R3 smp1 prs0 timing");
        chk(result_o == 10'h3FF, "R4 full-scale", result_o, 10'h3FF);
        vin = 10'h000;
        cfg_clk(1'b0, 2, 31);
        wr(2'd2, 8'h00);
        expect_done(L * conv_len(1'b0, 2, 31), "R2 R3 prs31 smp2 timing");
        chk(result_o == 10'h000, "R4 zero-scale", result_o, 0);
    endtask

    task automatic t_abort();
        int p0;
        vin = 10'h155;
        cfg_clk(1'b0, 0, 1);
        wr(2'd2, 8'h00);
        repeat (20) @(negedge clk);
        p0 = pulses;
        wr(2'd1, 8'h01);
        chk(samp_o == 0 && trial_o == 0 && done_o == 0, "R6 abort idle",
            {samp_o, trial_o, done_o}, 0);
        repeat (300) @(negedge clk);
        chk(done_o == 0 && pulses == p0, "R6 stays idle", pulses - p0, 0);
        wr(2'd2, 8'h00);
        expect_done(L * 48, "R6 restart after abort");
        wr(2'd0, 8'h00);
        chk(done_o == 0, "R6 control write clears done", done_o, 0);
    endtask

    task automatic t_restart();
        wr(2'd2, 8'h00);
        repeat (29) @(negedge clk);
        wr(2'd2, 8'h00);
        expect_done(L * 48, "R7 restart timing");
        wr(2'd2, 8'h00);
        chk(done_o == 0, "R7 start clears done", done_o, 0);
        repeat (L * 48) @(negedge clk);
    endtask

    task automatic t_frz_run();
        for (int f = 0; f < 2; f++) begin
            wr(2'd0, f[7:0]);
            wr(2'd2, 8'h00);
            dbg_halt = 1'b1;
            expect_done(L * 48, "R8 halt ignored");
            dbg_halt = 1'b0;
            chk(result_o == exp_res(), "R8 result", result_o, exp_res());
        end
    endtask

    task automatic t_frz_finish();
        int p0;
        wr(2'd0, 8'h02);
        vin = 10'h155;
        cfg_clk(1'b0, 0, 0);
        p0 = pulses;
        wr(2'd2, 8'h00);
        repeat (5) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (35) @(negedge clk);
        chk(samp_o == 0 && trial_o == 0, "R9 holding", {samp_o, trial_o}, 0);
        chk(result_o == 10'h055 && pulses - p0 == 1, "R9 finished one", pulses - p0, 1);
        repeat (20) @(negedge clk);
        dbg_halt = 1'b0;
        expect_done(1 + (L - 1) * 24, "R9 resume timing");
    endtask

    task automatic t_frz_stop();
        int p0;
        logic [9:0] snap_t;
        logic snap_s;
        wr(2'd0, 8'h03);
        cfg_clk(1'b0, 0, 0);
        p0 = pulses;
        wr(2'd2, 8'h00);
        repeat (33) @(negedge clk);
        dbg_halt = 1'b1;
        snap_t = trial_o; snap_s = samp_o;
        repeat (17) @(negedge clk);
        chk(trial_o == snap_t && samp_o == snap_s, "R10 frozen outputs", trial_o, snap_t);
        chk(pulses - p0 == 1 && done_o == 0, "R10 frozen progress", pulses - p0, 1);
        dbg_halt = 1'b0;
        expect_done(L * 24 + 17 - 50, "R10 delayed by halt");
        chk(result_o == exp_res(), "R10 result", result_o, exp_res());
    endtask

    task automatic t_same_cycle();
        int p0;
        wr(2'd0, 8'h00);
        cfg_clk(1'b0, 0, 0);
        p0 = pulses;
        wr(2'd2, 8'h00);
        repeat (L * 24 - 1) @(negedge clk);
        wr(2'd1, 8'h00);
        chk(done_o == 0, "R11 abort beats completion", done_o, 0);
        repeat (50) @(negedge clk);
        chk(done_o == 0 && pulses - p0 == L - 1, "R11 last pulse dropped", pulses - p0, L - 1);
    endtask

    task automatic t_ignored_addr();
        vin = 10'h0F0;
        wr(2'd2, 8'h00);
        repeat (9) @(negedge clk);
        wr(2'd3, 8'hFF);
        expect_done(L * 24 - 10, "R12 address 3 ignored");
        chk(result_o == exp_res(), "R12 result intact", result_o, exp_res());
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_default_seq();
        t_modes();
        t_abort();
        t_restart();
        t_frz_run();
        t_frz_finish();
        t_frz_stop();
        t_same_cycle();
        t_ignored_addr();
        summary();
    end

endmodule